// File: doc/BRIEF.md
# DMA Channel Address Permission Checker

This block decides, one request at a time, whether a DMA channel may read or write a given address. A request carries a channel number, a 32-bit byte address and a write flag. The block tests it against sixteen region descriptors held elsewhere and presented here as flat buses. A descriptor has four parts: a start page, an end page, a channel mask and a two-bit permission code.

A page is 4 KB, so a bound keeps only address bits 31 to 12. The start bound covers addresses from the first byte of its page. The end bound covers addresses up to the last byte of its page. An access is granted when at least one region meets three conditions: its mask selects the channel, its range contains the address, and its code permits the access type. The block returns a registered verdict one clock after the request. A global enable turns protection off, and then every request is granted.

The verdict feeds the DMA engine's address issue stage. A denied transfer is then stopped, and the violation flag is passed to whatever logs or reports faults.

Top module: `dma_perm_checker`

## Requirements
- R1: While reset is held and after it is released, `resp_valid`, `resp_allow` and `resp_violation` are all 0 until a request is presented.
- R2: A request with `req_valid`=1 at a rising edge produces `resp_valid`=1 after that edge. In that response, exactly one of `resp_allow` and `resp_violation` is 1.
- R3: The start bound is inclusive at the first byte of its page. The region covers an address exactly when {start_page, 12'h000} <= address.
- R4: The end bound is inclusive up to the last byte of its page. The region covers an address exactly when address <= {end_page, 12'hFFF}. This also holds for the topmost page.
- R5: A region applies to channel n (1 to 10) only when bit n-1 of that region's mask field is 1.
- R6: Code 2'b00 grants nothing. Code 2'b01 grants reads only (`req_write`=0). Codes 2'b10 and 2'b11 grant both reads and writes.
- R7: With `mpu_enable`=0, every request is granted, whatever the channel, address or region contents.
- R8: With `mpu_enable`=1, channel numbers 0 and 11 to 15 are always denied.
- R9: A region whose start page is greater than its end page covers no address.
- R10: A request is granted if any single region grants it. A region that matches but refuses the access type does not block a grant from another region.
- R11: In a cycle after no request was presented, `resp_valid`, `resp_allow` and `resp_violation` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mpu_enable | input | 1 | 1 = protection applied, 0 = everything granted |
| cfg_start_page | input | 320 | Start page of each region, 20 bits per region; region r occupies bits [r*20 +: 20] |
| cfg_end_page | input | 320 | End page of each region, 20 bits per region; region r occupies bits [r*20 +: 20] |
| cfg_chan_mask | input | 160 | Channel mask of each region, 10 bits per region; bit n-1 selects channel n |
| cfg_perm_code | input | 32 | Permission code of each region, 2 bits per region |
| req_valid | input | 1 | A request is present this cycle |
| req_chan | input | 4 | Requesting channel number, 1 to 10 valid |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| resp_valid | output | 1 | Verdict for the request of the previous cycle is present |
| resp_allow | output | 1 | Access granted |
| resp_violation | output | 1 | Access denied while a verdict is present |

## Verification
The case that needs most care is two regions covering the same page, each answering differently in the same cycle. One region selects every channel but allows reads only. A second region selects a single channel and allows writes. The bench programs both. It then issues writes from the selected channel and from another channel, and a read from the other channel. The expected result is a grant for the selected channel's write, a violation for the other channel's write and a grant for its read. This shows the verdicts of the two regions are combined with OR, and that a refusal from one region does not override the other. The bench also presents an invalid channel number while the enable is low. That case must be granted, so the bypass takes priority over the channel range check.

// File: rtl/dmp_pkg.sv
package dmp_pkg;

    // Two-bit permission encoding carried per region.
    typedef enum logic [1:0] {
        PERM_NONE = 2'b00,
        PERM_READ = 2'b01,
        PERM_RW_A = 2'b10,
        PERM_RW_B = 2'b11
    } perm_code_e;

    // Registered verdict of one request.
    typedef struct packed {
        logic valid;
        logic allow;
        logic deny;
    } verdict_t;

endpackage

// File: rtl/dmp_chan_decode.sv
module dmp_chan_decode #(
    parameter int NUM_CHANNELS = 10,
    parameter int CHAN_W       = 4
) (
    input  logic [CHAN_W-1:0]       chan,
    output logic [NUM_CHANNELS-1:0] chan_sel,
    output logic                    chan_ok
);

    // Channel numbers start at 1: select line i stands for channel i+1.
    for (genvar i = 0; i < NUM_CHANNELS; i++) begin : g_sel
        assign chan_sel[i] = (chan == CHAN_W'(i + 1));
    end

    assign chan_ok = |chan_sel;

endmodule

// File: rtl/dmp_region_match.sv
module dmp_region_match
    import dmp_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int PAGE_BITS    = 12,
    parameter int NUM_CHANNELS = 10,
    localparam int PAGE_W      = ADDR_W - PAGE_BITS
) (
    input  logic [PAGE_W-1:0]       start_page,
    input  logic [PAGE_W-1:0]       end_page,
    input  logic [NUM_CHANNELS-1:0] chan_mask,
    input  logic [1:0]              perm_code,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [NUM_CHANNELS-1:0] chan_sel,
    input  logic                    is_write,
    output logic                    grant
);

    logic [ADDR_W-1:0] lo_addr;
    logic [ADDR_W-1:0] hi_addr;
    logic              in_range;
    logic              chan_hit;
    logic              type_ok;

    always_comb begin
        // Start sits at the first byte of its page, end at the last byte.
        lo_addr  = {start_page, {PAGE_BITS{1'b0}}};
        hi_addr  = {end_page, {PAGE_BITS{1'b1}}};
        // Start above end leaves this empty.
        in_range = (addr >= lo_addr) && (addr <= hi_addr);
        chan_hit = |(chan_mask & chan_sel);
        unique case (perm_code_e'(perm_code))
            PERM_NONE: type_ok = 1'b0;
            PERM_READ: type_ok = !is_write;
            PERM_RW_A,
            PERM_RW_B: type_ok = 1'b1;
            default:   type_ok = 1'b0;
        endcase
        grant = in_range && chan_hit && type_ok;
    end

endmodule

// File: rtl/dma_perm_checker.sv
module dma_perm_checker
    import dmp_pkg::*;
#(
    parameter int NUM_REGIONS  = 16,
    parameter int NUM_CHANNELS = 10,
    parameter int ADDR_W       = 32,
    parameter int PAGE_BITS    = 12,
    parameter int CHAN_W       = 4,
    localparam int PAGE_W      = ADDR_W - PAGE_BITS,
    localparam int CODE_W      = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              mpu_enable,
    input  logic [NUM_REGIONS*PAGE_W-1:0]     cfg_start_page,
    input  logic [NUM_REGIONS*PAGE_W-1:0]     cfg_end_page,
    input  logic [NUM_REGIONS*NUM_CHANNELS-1:0] cfg_chan_mask,
    input  logic [NUM_REGIONS*CODE_W-1:0]     cfg_perm_code,
    input  logic                              req_valid,
    input  logic [CHAN_W-1:0]                 req_chan,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic                              req_write,
    output logic                              resp_valid,
    output logic                              resp_allow,
    output logic                              resp_violation
);

    logic [NUM_CHANNELS-1:0] chan_sel;
    logic                    chan_ok;
    logic [NUM_REGIONS-1:0]  region_grant;
    logic                    any_grant;
    logic                    permit;
    verdict_t                verdict_d;
    verdict_t                verdict_q;

    dmp_chan_decode #(
        .NUM_CHANNELS (NUM_CHANNELS),
        .CHAN_W       (CHAN_W)
    ) u_decode (
        .chan     (req_chan),
        .chan_sel (chan_sel),
        .chan_ok  (chan_ok)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        dmp_region_match #(
            .ADDR_W       (ADDR_W),
            .PAGE_BITS    (PAGE_BITS),
            .NUM_CHANNELS (NUM_CHANNELS)
        ) u_match (
            .start_page (cfg_start_page[r*PAGE_W +: PAGE_W]),
            .end_page   (cfg_end_page[r*PAGE_W +: PAGE_W]),
            .chan_mask  (cfg_chan_mask[r*NUM_CHANNELS +: NUM_CHANNELS]),
            .perm_code  (cfg_perm_code[r*CODE_W +: CODE_W]),
            .addr       (req_addr),
            .chan_sel   (chan_sel),
            .is_write   (req_write),
            .grant      (region_grant[r])
        );
    end

    assign any_grant = |region_grant;

    always_comb begin
        // Bypass first, then an out-of-range channel denies outright.
        permit          = !mpu_enable || (chan_ok && any_grant);
        verdict_d       = '0;
        verdict_d.valid = req_valid;
        verdict_d.allow = req_valid && permit;
        verdict_d.deny  = req_valid && !permit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            verdict_q <= '0;
        end else begin
            verdict_q <= verdict_d;
        end
    end

    assign resp_valid     = verdict_q.valid;
    assign resp_allow     = verdict_q.allow;
    assign resp_violation = verdict_q.deny;

endmodule

// File: rtl/dmp_guard_chk.sv
module dmp_guard_chk #(
    parameter int NUM_CHANNELS = 10,
    parameter int CHAN_W       = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mpu_enable,
    input logic              req_valid,
    input logic [CHAN_W-1:0] req_chan,
    input logic              resp_valid,
    input logic              resp_allow,
    input logic              resp_violation
);

    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> resp_valid);

    // R2
    single_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($countones({resp_allow, resp_violation}) == 1));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!resp_valid && !resp_allow && !resp_violation));

    // R7
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mpu_enable) |=> resp_allow);

    // R8
    bad_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mpu_enable &&
         ((req_chan == '0) || (int'(req_chan) > NUM_CHANNELS)))
        |=> resp_violation);

endmodule

bind dma_perm_checker dmp_guard_chk #(
    .NUM_CHANNELS (NUM_CHANNELS),
    .CHAN_W       (CHAN_W)
) u_guard_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .mpu_enable     (mpu_enable),
    .req_valid      (req_valid),
    .req_chan       (req_chan),
    .resp_valid     (resp_valid),
    .resp_allow     (resp_allow),
    .resp_violation (resp_violation)
);

// File: tb/sim_dma_perm_checker.sv
module sim_dma_perm_checker;

    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;
    localparam int NC = 10;
    localparam int PW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mpu_enable = 1'b1;
    logic [NR*PW-1:0] cfg_start_page = '0;
    logic [NR*PW-1:0] cfg_end_page = '0;
    logic [NR*NC-1:0] cfg_chan_mask = '0;
    logic [NR*2-1:0]  cfg_perm_code = '0;
    logic          req_valid = 1'b0;
    logic [3:0]    req_chan = '0;
    logic [31:0]   req_addr = '0;
    logic          req_write = 1'b0;
    logic          resp_valid;
    logic          resp_allow;
    logic          resp_violation;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_perm_checker u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .mpu_enable     (mpu_enable),
        .cfg_start_page (cfg_start_page),
        .cfg_end_page   (cfg_end_page),
        .cfg_chan_mask  (cfg_chan_mask),
        .cfg_perm_code  (cfg_perm_code),
        .req_valid      (req_valid),
        .req_chan       (req_chan),
        .req_addr       (req_addr),
        .req_write      (req_write),
        .resp_valid     (resp_valid),
        .resp_allow     (resp_allow),
        .resp_violation (resp_violation)
    );

    task automatic expect_bits(input string tag, input logic [2:0] got, input logic [2:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: {valid,allow,violation} actual=%b expected=%b", tag, got, exp);
        end
    endtask

    task automatic set_region(input int idx, input logic [19:0] s, input logic [19:0] e,
                              input logic [9:0] m, input logic [1:0] c);
        @(negedge clk);
        cfg_start_page[idx*PW +: PW] = s;
        cfg_end_page[idx*PW +: PW]   = e;
        cfg_chan_mask[idx*NC +: NC]  = m;
        cfg_perm_code[idx*2 +: 2]    = c;
    endtask

    // Present one request, sample the registered verdict at the next falling edge.
    task automatic probe(input string tag, input logic [3:0] ch, input logic [31:0] a,
                         input logic wr, input logic exp_allow);
        @(negedge clk);
        req_valid = 1'b1;
        req_chan  = ch;
        req_addr  = a;
        req_write = wr;
        @(negedge clk);
        req_valid = 1'b0;
        expect_bits(tag, {resp_valid, resp_allow, resp_violation}, {1'b1, exp_allow, !exp_allow});
    endtask

    task automatic t_reset();
        #1;
        expect_bits("R1 in reset", {resp_valid, resp_allow, resp_violation}, 3'b000);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_bits("R1 after reset", {resp_valid, resp_allow, resp_violation}, 3'b000);
    endtask

    task automatic t_bounds();
        set_region(0, 20'h00010, 20'h00012, 10'b00_0000_0001, 2'b10);
        probe("R3 first byte", 4'd1, 32'h0001_0000, 1'b0, 1'b1);
        probe("R3 below start", 4'd1, 32'h0000_FFFF, 1'b0, 1'b0);
        probe("R4 last byte", 4'd1, 32'h0001_2FFF, 1'b0, 1'b1);
        probe("R4 past end", 4'd1, 32'h0001_3000, 1'b0, 1'b0);
        probe("R2 write inside", 4'd1, 32'h0001_1234, 1'b1, 1'b1);
        set_region(7, 20'hFFFFF, 20'hFFFFF, 10'b00_0000_0001, 2'b11);
        probe("R4 top page", 4'd1, 32'hFFFF_FFFF, 1'b1, 1'b1);
    endtask

    task automatic t_mask();
        probe("R5 unmasked channel", 4'd2, 32'h0001_0000, 1'b0, 1'b0);
        set_region(1, 20'h00020, 20'h00020, 10'b10_0000_0000, 2'b01);
        probe("R5 channel 10 bit 9", 4'd10, 32'h0002_0ABC, 1'b0, 1'b1);
        probe("R5 channel 9 not set", 4'd9, 32'h0002_0ABC, 1'b0, 1'b0);
    endtask

    task automatic t_codes();
        probe("R6 code 01 write", 4'd10, 32'h0002_0000, 1'b1, 1'b0);
        set_region(2, 20'h00030, 20'h00030, 10'h3FF, 2'b00);
        probe("R6 code 00 read", 4'd5, 32'h0003_0000, 1'b0, 1'b0);
        set_region(3, 20'h00040, 20'h00040, 10'h3FF, 2'b11);
        probe("R6 code 11 write", 4'd5, 32'h0004_0010, 1'b1, 1'b1);
    endtask

    task automatic t_inverted();
        set_region(4, 20'h00050, 20'h0004F, 10'h3FF, 2'b10);
        probe("R9 inverted low", 4'd3, 32'h0004_F000, 1'b0, 1'b0);
        probe("R9 inverted high", 4'd3, 32'h0005_0000, 1'b0, 1'b0);
    endtask

    task automatic t_overlap();
        set_region(5, 20'h00060, 20'h00060, 10'h3FF, 2'b01);
        set_region(6, 20'h00060, 20'h00060, 10'b00_0000_0100, 2'b10);
        probe("R10 write via second region", 4'd3, 32'h0006_0100, 1'b1, 1'b1);
        probe("R10 write refused", 4'd4, 32'h0006_0100, 1'b1, 1'b0);
        probe("R10 read via first region", 4'd4, 32'h0006_0100, 1'b0, 1'b1);
    endtask

    task automatic t_bad_chan();
        probe("R8 channel 0", 4'd0, 32'h0004_0000, 1'b0, 1'b0);
        probe("R8 channel 11", 4'd11, 32'h0004_0000, 1'b0, 1'b0);
        probe("R8 channel 15", 4'd15, 32'h0004_0000, 1'b0, 1'b0);
    endtask

    task automatic t_bypass();
        @(negedge clk);
        mpu_enable = 1'b0;
        probe("R7 channel 0 write", 4'd0, 32'hFFFF_FFFF, 1'b1, 1'b1);
        probe("R7 unmapped write", 4'd2, 32'h0000_0000, 1'b1, 1'b1);
        @(negedge clk);
        mpu_enable = 1'b1;
        probe("R7 re-enabled", 4'd2, 32'h0000_0000, 1'b1, 1'b0);
    endtask

    task automatic t_idle();
        @(negedge clk);
        @(negedge clk);
        expect_bits("R11 idle", {resp_valid, resp_allow, resp_violation}, 3'b000);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        t_reset();
        t_bounds();
        t_mask();
        t_codes();
        t_inverted();
        t_overlap();
        t_bad_chan();
        t_bypass();
        t_idle();
        report();
    end

    initial begin
        #(CLK_PERIOD * 20000);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
    end

endmodule